// File: doc/BRIEF.md
# Priority PMP Access Checker

This block decides whether one memory access may proceed under a set of physical memory protection entries. For each request it takes the start address, the access length, the requested permissions (read, write, execute) and whether the requester runs in machine mode. It then scans the protection entries from the lowest index upward. The first entry whose range contains either end of the access decides the outcome. If only one end of the access lies inside that range, the access is refused outright.

The entries' byte ranges, configuration bytes and effective lock flags come from neighbouring blocks. Two policy bits come from the security control register: one turns on the lockdown rule table, and one makes unmatched accesses fail for every mode. With lockdown off, the block applies the classic rule. With lockdown on, a 16-row table gives separate machine and lower-mode results. Each result is registered, so it appears one cycle after its request.

Top module: `pmp_access_check`

## Requirements
- R1: Entries are scanned from index 0 upward, and only the first entry that contains either end of the access is used. An entry is active when configuration bits [4:3] are non-zero. Its range runs from its lower bound to its upper bound inclusive, both in bytes.
- R2: The first byte is `addr` and the last byte is `addr + len_m1`. If exactly one of them lies in the deciding entry's range, the allowed set is empty and the grant is 0.
- R3: Lockdown off and both ends inside the deciding entry: a machine-mode access to an entry whose lock input is 0 is allowed read, write and execute. Otherwise the allowed set is configuration bits [2:0]. Permission sets use bit 0 for read, bit 1 for write and bit 2 for execute.
- R4: Lockdown on and both ends inside: the table index is {cfg[7], cfg[0], cfg[1], cfg[2]}, that is lock, read, write, execute. For machine mode, indices 2, 3 and 14 give read-write. Indices 9 and 10 give execute. Indices 11 and 13 give read-execute. Indices 12 and 15 give read. All other indices give nothing.
- R5: Lockdown on and both ends inside, lower mode, same index: indices 1, 10 and 11 give execute. Indices 2, 4 and 15 give read. Indices 3 and 6 give read-write. Index 5 gives read-execute. Index 7 gives all three. All other indices give nothing.
- R6: When no entry contains either end (including when no entry is active), the default rule applies, with MMWP clear:
  - With lockdown on, machine mode gets read-write for a request without execute. Every other case is denied.
  - With lockdown off, machine mode gets all three and lower modes get nothing.
  - Under the default rule, the grant is 1 exactly when the allowed set is non-empty.
- R7: When no entry contains either end and the MMWP input is 1, the allowed set is empty and the grant is 0, whatever the mode or the lockdown bit.
- R8: When both ends are inside the deciding entry, the grant is 1 exactly when the requested set ANDed with the allowed set equals the requested set.
- R9: `rsp_valid` is `req_valid` delayed by one clock. `rsp_allow` and `rsp_grant` show the result for the request of the previous cycle and hold while no request arrives.
- R10: During reset and until the first request, `rsp_valid`, `rsp_allow` and `rsp_grant` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | First byte address |
| req_len_m1 | input | LW | Access length in bytes minus one |
| req_perm | input | 3 | Requested set {X,W,R} |
| req_mmode | input | 1 | 1 for machine mode, 0 for lower modes |
| ent_lo | input | N_ENT*AW | Lower byte bound per entry, entry i in slice i |
| ent_hi | input | N_ENT*AW | Upper byte bound per entry (inclusive) |
| ent_cfg | input | N_ENT*8 | Configuration byte per entry: [2:0] R,W,X, [4:3] match mode, [7] lock |
| ent_lock | input | N_ENT | Effective lock state per entry |
| sec_mml | input | 1 | Lockdown rule table enable |
| sec_mmwp | input | 1 | Deny unmatched accesses in every mode |
| rsp_valid | output | 1 | Result present |
| rsp_allow | output | 3 | Allowed set {X,W,R} |
| rsp_grant | output | 1 | Access permitted |

## Verification
The bench builds the block with four entries, a 12-bit address and a 3-bit length field. With these values, random bounds and addresses placed near entry edges often make accesses straddle a boundary, and several entries often overlap, so the partial-deny and priority paths are exercised often. A directed sweep covers all 16 lockdown table rows against all eight requested sets in both modes, with and without lockdown. A second sweep runs the unmatched default under every combination of the two policy bits.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

    localparam int PERM_W = 3;

    typedef logic [PERM_W-1:0] perm_t;   // bit0 read, bit1 write, bit2 execute

    typedef struct packed {
        logic  valid;
        perm_t allow;
        logic  grant;
    } rsp_state_t;

    localparam perm_t P_NONE = 3'b000;
    localparam perm_t P_R    = 3'b001;
    localparam perm_t P_RW   = 3'b011;
    localparam perm_t P_X    = 3'b100;
    localparam perm_t P_RX   = 3'b101;
    localparam perm_t P_RWX  = 3'b111;

    // Lockdown table, index = {lock, read, write, execute}
    function automatic perm_t lockdown_perm(input logic [3:0] idx, input logic mmode);
        perm_t res;
        res = P_NONE;
        if (mmode) begin
            case (idx)
                4'd2, 4'd3, 4'd14: res = P_RW;
                4'd9, 4'd10:       res = P_X;
                4'd11, 4'd13:      res = P_RX;
                4'd12, 4'd15:      res = P_R;
                default:           res = P_NONE;
            endcase
        end else begin
            case (idx)
                4'd1, 4'd10, 4'd11: res = P_X;
                4'd2, 4'd4, 4'd15:  res = P_R;
                4'd3, 4'd6:         res = P_RW;
                4'd5:               res = P_RX;
                4'd7:               res = P_RWX;
                default:            res = P_NONE;
            endcase
        end
        return res;
    endfunction

endpackage

// File: rtl/pmp_entry_cmp.sv
module pmp_entry_cmp #(
    parameter int AW = 34
) (
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [1:0]    mode,
    output logic          full,
    output logic          partial
);
    logic active;
    logic first_in;
    logic last_in;

    always_comb begin
        active   = (mode != 2'b00);
        first_in = (first_addr >= lo) && (first_addr <= hi);
        last_in  = (last_addr >= lo) && (last_addr <= hi);
        full     = active && first_in && last_in;
        partial  = active && (first_in ^ last_in);
    end
endmodule

// File: rtl/pmp_priority_pick.sv
module pmp_priority_pick #(
    parameter int N_ENT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_ENT-1:0]   full,
    input  logic [N_ENT-1:0]   partial,
    input  logic [N_ENT*8-1:0] cfg,
    input  logic [N_ENT-1:0]   lock,
    output logic               any_hit,
    output logic               sel_partial,
    output logic [7:0]         sel_cfg,
    output logic               sel_lock
);
    logic [N_ENT-1:0] hit;
    logic [N_ENT-1:0] sel_oh;

    always_comb begin
        logic seen;
        hit         = full | partial;
        seen        = 1'b0;
        sel_oh      = '0;
        sel_partial = 1'b0;
        sel_cfg     = '0;
        sel_lock    = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            sel_oh[i] = hit[i] && !seen;
            seen      = seen | hit[i];
            if (sel_oh[i]) begin
                sel_partial = partial[i];
                sel_cfg     = cfg[i*8 +: 8];
                sel_lock    = lock[i];
            end
        end
        any_hit = seen;
    end

    // R1: at most one entry decides
    assert_single_winner_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh));

    // R1: a hit anywhere yields a winner
    assert_hit_has_winner_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> (sel_oh != '0));
endmodule

// File: rtl/pmp_perm_rule.sv
module pmp_perm_rule
    import pmp_chk_pkg::*;
(
    input  logic [7:0] cfg,
    input  logic       locked,
    input  logic       mml,
    input  logic       mmode,
    output perm_t      allow
);
    logic [3:0] tbl_idx;

    always_comb begin
        tbl_idx = {cfg[7], cfg[0], cfg[1], cfg[2]};
        if (mml) begin
            allow = lockdown_perm(tbl_idx, mmode);
        end else if (mmode && !locked) begin
            allow = P_RWX;
        end else begin
            allow = cfg[2:0];
        end
    end

    // R4: machine mode under lockdown never receives all three permissions
    always_comb begin
        if (mml && mmode) begin
            assert_mml_m_no_rwx_R4: assert (allow != P_RWX);
        end
    end
endmodule

// File: rtl/pmp_access_check.sv
module pmp_access_check
    import pmp_chk_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int AW    = 34,
    parameter int LW    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [AW-1:0]      req_addr,
    input  logic [LW-1:0]      req_len_m1,
    input  logic [2:0]         req_perm,
    input  logic               req_mmode,
    input  logic [N_ENT*AW-1:0] ent_lo,
    input  logic [N_ENT*AW-1:0] ent_hi,
    input  logic [N_ENT*8-1:0] ent_cfg,
    input  logic [N_ENT-1:0]   ent_lock,
    input  logic               sec_mml,
    input  logic               sec_mmwp,
    output logic               rsp_valid,
    output logic [2:0]         rsp_allow,
    output logic               rsp_grant
);
    localparam int MODE_LSB = 3;

    logic [AW-1:0]    last_addr;
    logic [N_ENT-1:0] ent_full;
    logic [N_ENT-1:0] ent_partial;
    logic             any_hit;
    logic             sel_partial;
    logic [7:0]       sel_cfg;
    logic             sel_lock;
    perm_t            match_allow;
    rsp_state_t       state_d;
    rsp_state_t       state_q;

    assign last_addr = req_addr + AW'(req_len_m1);

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        pmp_entry_cmp #(.AW(AW)) i_cmp (
            .first_addr (req_addr),
            .last_addr  (last_addr),
            .lo         (ent_lo[g*AW +: AW]),
            .hi         (ent_hi[g*AW +: AW]),
            .mode       (ent_cfg[g*8+MODE_LSB +: 2]),
            .full       (ent_full[g]),
            .partial    (ent_partial[g])
        );
    end

    pmp_priority_pick #(.N_ENT(N_ENT)) i_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .full        (ent_full),
        .partial     (ent_partial),
        .cfg         (ent_cfg),
        .lock        (ent_lock),
        .any_hit     (any_hit),
        .sel_partial (sel_partial),
        .sel_cfg     (sel_cfg),
        .sel_lock    (sel_lock)
    );

    pmp_perm_rule i_rule (
        .cfg    (sel_cfg),
        .locked (sel_lock),
        .mml    (sec_mml),
        .mmode  (req_mmode),
        .allow  (match_allow)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = req_valid;
        if (req_valid) begin
            if (any_hit && sel_partial) begin
                state_d.allow = P_NONE;
                state_d.grant = 1'b0;
            end else if (any_hit) begin
                state_d.allow = match_allow;
                state_d.grant = ((req_perm & match_allow) == req_perm);
            end else begin
                if (sec_mmwp) begin
                    state_d.allow = P_NONE;
                end else if (sec_mml) begin
                    state_d.allow = (req_mmode && !req_perm[2]) ? P_RW : P_NONE;
                end else begin
                    state_d.allow = req_mmode ? P_RWX : P_NONE;
                end
                state_d.grant = (state_d.allow != P_NONE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = state_q.valid;
    assign rsp_allow = state_q.allow;
    assign rsp_grant = state_q.grant;

    // R9: response follows request by one cycle
    assert_valid_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && $stable(rsp_allow) && $stable(rsp_grant));

    // R2: straddling access is refused
    assert_partial_deny_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && any_hit && sel_partial) |=> (rsp_allow == 3'b000) && !rsp_grant);

    // R7: unmatched access under MMWP is refused
    assert_mmwp_deny_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !any_hit && sec_mmwp) |=> (rsp_allow == 3'b000) && !rsp_grant);

    // R8: a grant never covers more than was allowed
    assert_grant_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant) |-> (($past(req_perm) & rsp_allow) == $past(req_perm)));
endmodule

// File: tb/test_pmp_access_check.sv
module test_pmp_access_check;
    localparam int N  = 4;
    localparam int AW = 12;
    localparam int LW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [LW-1:0]   req_len_m1 = '0;
    logic [2:0]      req_perm = '0;
    logic            req_mmode = 1'b0;
    logic [N*AW-1:0] ent_lo = '0;
    logic [N*AW-1:0] ent_hi = '0;
    logic [N*8-1:0]  ent_cfg = '0;
    logic [N-1:0]    ent_lock = '0;
    logic            sec_mml = 1'b0;
    logic            sec_mmwp = 1'b0;
    logic            rsp_valid;
    logic [2:0]      rsp_allow;
    logic            rsp_grant;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int    exp_valid = 0;
    int    exp_allow = 0;
    int    exp_grant = 0;
    string exp_tag = "R10";

    always #5 clk = ~clk;

    pmp_access_check #(.N_ENT(N), .AW(AW), .LW(LW)) i_pmp_access_check (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len_m1(req_len_m1), .req_perm(req_perm), .req_mmode(req_mmode),
        .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_cfg(ent_cfg), .ent_lock(ent_lock),
        .sec_mml(sec_mml), .sec_mmwp(sec_mmwp),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_grant(rsp_grant)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int mml_table(input int l, input int r, input int w, input int x, input int m);
        int k;
        k = l * 8 + r * 4 + w * 2 + x;
        if (m != 0) begin
            if (k inside {2, 3, 14}) return 3;
            if (k inside {9, 10})    return 4;
            if (k inside {11, 13})   return 5;
            if (k inside {12, 15})   return 1;
            return 0;
        end
        if (k inside {1, 10, 11}) return 4;
        if (k inside {2, 4, 15})  return 1;
        if (k inside {3, 6})      return 3;
        if (k == 5)               return 5;
        if (k == 7)               return 7;
        return 0;
    endfunction

    // behavioural reference: evaluates the current inputs
    task automatic model();
        int a_first, a_last, hits, win, win_part;
        a_first = int'(req_addr);
        a_last  = a_first + int'(req_len_m1);
        hits = 0; win = -1; win_part = 0;
        for (int i = 0; i < N; i++) begin
            int lo, hi, fi, li;
            lo = int'(ent_lo[i*AW +: AW]);
            hi = int'(ent_hi[i*AW +: AW]);
            fi = (a_first >= lo && a_first <= hi) ? 1 : 0;
            li = (a_last >= lo && a_last <= hi) ? 1 : 0;
            if (ent_cfg[i*8+3 +: 2] != 2'b00 && (fi + li) > 0) begin
                hits++;
                if (win < 0) begin
                    win = i;
                    win_part = (fi != li) ? 1 : 0;
                end
            end
        end
        exp_valid = int'(req_valid);
        if (!req_valid) return;
        if (win < 0) begin
            if (sec_mmwp) begin
                exp_allow = 0; exp_tag = "R7";
            end else if (sec_mml) begin
                exp_allow = (req_mmode && !req_perm[2]) ? 3 : 0; exp_tag = "R6";
            end else begin
                exp_allow = req_mmode ? 7 : 0; exp_tag = "R6";
            end
            exp_grant = (exp_allow != 0) ? 1 : 0;
        end else if (win_part != 0) begin
            exp_allow = 0; exp_grant = 0; exp_tag = "R2";
        end else begin
            logic [7:0] c;
            c = ent_cfg[win*8 +: 8];
            if (sec_mml) begin
                exp_allow = mml_table(int'(c[7]), int'(c[0]), int'(c[1]), int'(c[2]), int'(req_mmode));
                exp_tag = req_mmode ? "R4" : "R5";
            end else begin
                exp_allow = (req_mmode && !ent_lock[win]) ? 7 : int'(c[2:0]);
                exp_tag = "R3";
            end
            exp_grant = ((int'(req_perm) & exp_allow) == int'(req_perm)) ? 1 : 0;
        end
        if (hits > 1) exp_tag = {exp_tag, "/R1"};
    endtask

    // compare last cycle's prediction, then predict for freshly driven inputs
    task automatic step_check();
        check("R9 valid", int'(rsp_valid), exp_valid);
        check({exp_tag, " allow"}, int'(rsp_allow), exp_allow);
        check("R8 grant", int'(rsp_grant), exp_grant);
    endtask

    task automatic set_entry(input int i, input int lo, input int hi, input int cfg, input int lk);
        ent_lo[i*AW +: AW] = AW'(lo);
        ent_hi[i*AW +: AW] = AW'(hi);
        ent_cfg[i*8 +: 8]  = 8'(cfg);
        ent_lock[i]        = lk[0];
    endtask

    task automatic cycle_drive();
        model();
        @(negedge clk);
        step_check();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset valid", int'(rsp_valid), 0);
        check("R10 reset allow", int'(rsp_allow), 0);
        check("R10 reset grant", int'(rsp_grant), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle valid", int'(rsp_valid), 0);
        check("R10 idle grant", int'(rsp_grant), 0);

        // no active rule: default rule only (R6, R7)
        for (int k = 0; k < 32; k++) begin
            req_valid = 1; req_addr = 12'd500; req_len_m1 = 3'd3;
            req_perm = 3'(k); sec_mml = k[3]; sec_mmwp = k[4];
            req_mmode = (k % 3) != 0;
            cycle_drive();
        end

        // lockdown table and legacy rule sweep on one entry (R3, R4, R5, R8)
        set_entry(0, 100, 199, 0, 0);
        for (int m = 0; m < 2; m++) begin
            for (int md = 0; md < 2; md++) begin
                for (int idx = 0; idx < 16; idx++) begin
                    for (int rq = 0; rq < 8; rq++) begin
                        int cfg;
                        cfg = ((idx >> 3) & 1) * 128 + ((idx >> 2) & 1) + ((idx >> 1) & 1) * 2
                              + (idx & 1) * 4 + 8;
                        set_entry(0, 100, 199, cfg, (idx >> 3) & 1);
                        sec_mml = m[0]; sec_mmwp = 1'b0; req_mmode = md[0];
                        req_valid = 1; req_addr = 12'd120; req_len_m1 = 3'd3; req_perm = 3'(rq);
                        cycle_drive();
                    end
                end
            end
        end

        // partial overlap at both edges (R2)
        set_entry(0, 100, 199, 8'h0F, 0);
        req_addr = 12'd98; req_len_m1 = 3'd3; req_perm = 3'b001; req_mmode = 1; sec_mml = 0;
        cycle_drive();
        req_addr = 12'd197;
        cycle_drive();
        req_addr = 12'd196;  // last byte 199 exactly: full match
        cycle_drive();

        // random mixes near entry boundaries (R1..R9)
        for (int it = 0; it < 4000; it++) begin
            if (it % 40 == 0) begin
                for (int i = 0; i < N; i++) begin
                    int lo, sp;
                    lo = $urandom_range(0, 3900);
                    sp = $urandom_range(0, 80);
                    set_entry(i, lo, lo + sp, int'($urandom_range(0, 255)), int'($urandom_range(0, 1)));
                end
                sec_mml = $urandom_range(0, 1); sec_mmwp = ($urandom_range(0, 3) == 0);
            end
            begin
                int e, base;
                e = $urandom_range(0, N - 1);
                base = ($urandom_range(0, 1) != 0) ? int'(ent_lo[e*AW +: AW]) : int'(ent_hi[e*AW +: AW]);
                base = base + $urandom_range(0, 14) - 7;
                if (base < 0) base = 0;
                if (base > 4080) base = 4080;
                if ($urandom_range(0, 9) == 0) base = $urandom_range(0, 4080);
                req_addr = AW'(base);
            end
            req_len_m1 = 3'($urandom_range(0, 7));
            req_perm   = 3'($urandom_range(0, 7));
            req_mmode  = $urandom_range(0, 1);
            req_valid  = ($urandom_range(0, 4) != 0);
            cycle_drive();
        end

        req_valid = 0;
        cycle_drive();
        cycle_drive();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule